// File: doc/BRIEF.md
# Framed Command Memory Sequencer

This block sits between a byte-wide receive stream (typically fed by a UART receiver) and a byte-wide memory port that leads to a majority-voting bridge over replicated memories. It decodes framed command packets from the incoming stream. Each packet asks for a burst of reads or writes over consecutive addresses. The block runs that burst, one timed access at a time, and returns read data or status on an outgoing byte stream.

A packet is a start marker, a command byte, three address bytes, two length bytes, the write data when the command is a write, and a terminator. Every memory access holds chip select and its strobe for a fixed number of clock cycles. That hold time is set by a parameter, so the block can meet the access time of slow memory parts.

During a read, the voter reports a disagreement among the copies on its error input. The block then abandons the burst, reports the address that failed and goes back to waiting for a new packet.

Top module: `pkt_mem_seq`

## Requirements
- R1: While idle, `in_ready` is high and every incoming byte other than the start marker 0x7E is consumed and dropped, with no memory access and no output.
- R2: After 0x7E the block takes a command byte (0x52 = read, 0x57 = write), then three address bytes most significant first, of which only the low 19 bits of the 24-bit value are used, then a 16-bit length most significant first, then (writes only) that many data bytes, then the terminator 0x0A.
- R3: A command byte other than 0x52 or 0x57 discards the packet. The byte after it is examined as a possible start marker.
- R4: If a non-0x0A byte arrives where the terminator belongs, the packet is dropped. A read packet then performs no access and returns no byte. A write packet returns no acknowledge, but writes already made stay in memory.
- R5: Each access raises `mem_cs` together with exactly one of `mem_rd` or `mem_wr` for exactly `ACC_CYCLES` consecutive cycles. Address and write data stay stable throughout.
- R6: Write data bytes are stored one per access at consecutive addresses, starting at the given address and wrapping modulo 2^19. `in_ready` is low while an access is in progress.
- R7: After the terminator of a write packet the block sends the single byte 0x00. A write packet of length 0 writes nothing and is still acknowledged.
- R8: After the terminator of a read packet the block reads `length` consecutive addresses, wrapping modulo 2^19, and sends each byte read, in address order. A read of length 0 sends nothing.
- R9: If `vote_err` is high in the last cycle of a read access, that byte is not sent. The block sends 0xEE and then the failing address as three bytes, most significant first with the upper 5 bits zero. It makes no further access and returns to idle.
- R10: An offered output byte keeps `out_valid` high and `out_data` unchanged until `out_ready` is seen high, and the sequence waits for it.
- R11: After reset `in_ready` is high, `out_valid` is low and `mem_cs`, `mem_rd` and `mem_wr` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_data | input | 8 | Incoming command stream byte |
| in_valid | input | 1 | Incoming byte present |
| in_ready | output | 1 | Block accepts the incoming byte |
| out_data | output | 8 | Outgoing response byte |
| out_valid | output | 1 | Outgoing byte present |
| out_ready | input | 1 | Receiver accepts the outgoing byte |
| mem_cs | output | 1 | Memory chip select |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_addr | output | 19 | Memory address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Voted read data |
| vote_err | input | 1 | Voter disagreement flag |

## Verification
The assertions rely on the receiver of the outgoing stream following the valid/ready rule, while the incoming side may present any byte at any time. They also take `mem_rdata` and `vote_err` to be meaningful only in the last cycle of a read strobe. The bench drives `mem_rdata` as a pure function of `mem_addr` and raises `vote_err` only while a chosen address is being read. It keeps `in_valid` and `in_data` steady until the block accepts each byte, and it throttles `out_ready` in a fixed pattern, so every stall the assertions cover comes from legal handshakes.

// File: rtl/pms_pkg.sv
package pms_pkg;
    typedef enum logic [3:0] {
        ST_IDLE, ST_CMD, ST_ADR2, ST_ADR1, ST_ADR0, ST_LEN1, ST_LEN0,
        ST_WDAT, ST_WACC, ST_TERM, ST_RACC, ST_RSND, ST_ERR, ST_ACK
    } pms_state_e;

    localparam logic [7:0] BYTE_SOP    = 8'h7E;
    localparam logic [7:0] BYTE_EOP    = 8'h0A;
    localparam logic [7:0] BYTE_RD     = 8'h52;
    localparam logic [7:0] BYTE_WR     = 8'h57;
    localparam logic [7:0] BYTE_ACK    = 8'h00;
    localparam logic [7:0] BYTE_ERRTAG = 8'hEE;
endpackage

// File: rtl/pms_access_timer.sv
module pms_access_timer #(
    parameter int HOLD = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic active,
    output logic last
);
    localparam int CW = $clog2(HOLD + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start)
            cnt_d = CW'(HOLD);
        else if (cnt_q != '0)
            cnt_d = cnt_q - CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign active = (cnt_q != '0);
    assign last   = (cnt_q == CW'(1));

    // a new access never starts while one is running
    assert_start_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !active);
endmodule

// File: rtl/pms_status_fmt.sv
module pms_status_fmt
    import pms_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input  logic [1:0]        idx,
    input  logic [ADDR_W-1:0] addr,
    output logic [7:0]        byte_o
);
    localparam int PAD_W = 24;

    logic [PAD_W-1:0] wide;
    assign wide = PAD_W'(addr);

    always_comb begin
        case (idx)
            2'd0:    byte_o = BYTE_ERRTAG;
            2'd1:    byte_o = wide[23:16];
            2'd2:    byte_o = wide[15:8];
            default: byte_o = wide[7:0];
        endcase
    end
endmodule

// File: rtl/pkt_mem_seq.sv
module pkt_mem_seq
    import pms_pkg::*;
#(
    parameter int ADDR_W     = 19,
    parameter int LEN_W      = 16,
    parameter int ACC_CYCLES = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        in_data,
    input  logic              in_valid,
    output logic              in_ready,
    output logic [7:0]        out_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              mem_cs,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    input  logic              vote_err
);
    typedef struct packed {
        pms_state_e        st;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  remain;
        logic [7:0]        wdata;
        logic [7:0]        rdata;
        logic [1:0]        eidx;
    } seq_s;

    seq_s q, n;
    logic tmr_start, tmr_active, tmr_last;
    logic [7:0] stat_byte;
    logic in_take, out_take;
    logic [LEN_W-1:0] len_shift;

    pms_access_timer #(.HOLD(ACC_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(tmr_start),
        .active(tmr_active), .last(tmr_last)
    );

    pms_status_fmt #(.ADDR_W(ADDR_W)) u_fmt (
        .idx(q.eidx), .addr(q.addr), .byte_o(stat_byte)
    );

    assign in_take   = in_valid && in_ready;
    assign out_take  = out_valid && out_ready;
    assign len_shift = {q.remain[LEN_W-9:0], in_data};

    always_comb begin
        n         = q;
        tmr_start = 1'b0;
        in_ready  = 1'b0;
        out_valid = 1'b0;
        out_data  = BYTE_ACK;
        case (q.st)
            ST_IDLE: begin
                in_ready = 1'b1;
                if (in_valid && in_data == BYTE_SOP) n.st = ST_CMD;
            end
            ST_CMD: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    if (in_data == BYTE_RD)      begin n.wr = 1'b0; n.st = ST_ADR2; end
                    else if (in_data == BYTE_WR) begin n.wr = 1'b1; n.st = ST_ADR2; end
                    else                         n.st = ST_IDLE;
                end
            end
            ST_ADR2, ST_ADR1, ST_ADR0: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    n.addr = {q.addr[ADDR_W-9:0], in_data};
                    n.st   = (q.st == ST_ADR2) ? ST_ADR1 :
                             (q.st == ST_ADR1) ? ST_ADR0 : ST_LEN1;
                end
            end
            ST_LEN1: begin
                in_ready = 1'b1;
                if (in_valid) begin n.remain = len_shift; n.st = ST_LEN0; end
            end
            ST_LEN0: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    n.remain = len_shift;
                    n.st     = (q.wr && len_shift != '0) ? ST_WDAT : ST_TERM;
                end
            end
            ST_WDAT: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    n.wdata   = in_data;
                    tmr_start = 1'b1;
                    n.st      = ST_WACC;
                end
            end
            ST_WACC: begin
                if (tmr_last) begin
                    n.addr   = q.addr + ADDR_W'(1);
                    n.remain = q.remain - LEN_W'(1);
                    n.st     = (q.remain == LEN_W'(1)) ? ST_TERM : ST_WDAT;
                end
            end
            ST_TERM: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    if (in_data != BYTE_EOP)  n.st = ST_IDLE;
                    else if (q.wr)            n.st = ST_ACK;
                    else if (q.remain == '0)  n.st = ST_IDLE;
                    else begin tmr_start = 1'b1; n.st = ST_RACC; end
                end
            end
            ST_RACC: begin
                if (tmr_last) begin
                    if (vote_err) begin n.eidx = 2'd0; n.st = ST_ERR; end
                    else begin n.rdata = mem_rdata; n.st = ST_RSND; end
                end
            end
            ST_RSND: begin
                out_valid = 1'b1;
                out_data  = q.rdata;
                if (out_ready) begin
                    n.addr   = q.addr + ADDR_W'(1);
                    n.remain = q.remain - LEN_W'(1);
                    if (q.remain == LEN_W'(1)) n.st = ST_IDLE;
                    else begin tmr_start = 1'b1; n.st = ST_RACC; end
                end
            end
            ST_ERR: begin
                out_valid = 1'b1;
                out_data  = stat_byte;
                if (out_ready) begin
                    n.eidx = q.eidx + 2'd1;
                    if (q.eidx == 2'd3) n.st = ST_IDLE;
                end
            end
            ST_ACK: begin
                out_valid = 1'b1;
                out_data  = BYTE_ACK;
                if (out_ready) n.st = ST_IDLE;
            end
            default: n.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign mem_cs    = tmr_active;
    assign mem_rd    = tmr_active && (q.st == ST_RACC);
    assign mem_wr    = tmr_active && (q.st == ST_WACC);
    assign mem_addr  = q.addr;
    assign mem_wdata = q.wdata;

    // ---------------- assertions ----------------
    logic [15:0] cs_run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cs_run_q <= '0;
        else if (mem_cs) cs_run_q <= cs_run_q + 16'd1;
        else             cs_run_q <= '0;
    end

    assert_one_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cs |-> (mem_rd ^ mem_wr));
    assert_hold_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs && cs_run_q != '0) |-> (cs_run_q == 16'(ACC_CYCLES)));
    assert_addr_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_cs && $past(mem_cs)) |-> ($stable(mem_addr) && $stable(mem_wdata)));
    assert_busy_no_take_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cs |-> !in_take);
    assert_out_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
    assert_err_tag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && tmr_last && vote_err) |=> (out_valid && out_data == BYTE_ERRTAG && !mem_cs));
    assert_no_take_out_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_take |-> !in_ready);
endmodule

// File: tb/tb_pkt_mem_seq.sv
module tb_pkt_mem_seq;
    localparam int ACC = 6;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic in_valid = 1'b0, in_ready;
    logic [7:0] out_data;
    logic out_valid, out_ready;
    logic mem_cs, mem_rd, mem_wr;
    logic [18:0] mem_addr;
    logic [7:0] mem_wdata, mem_rdata;
    logic vote_err;

    logic err_on = 1'b0;
    logic [18:0] err_addr = '0;
    logic bp = 1'b0;
    int unsigned ncyc = 0;

    int vectors = 0, miscompares = 0;
    logic [7:0]  rx_buf [0:63];
    int rx_n = 0;
    logic [18:0] wr_a [0:63];
    logic [7:0]  wr_d [0:63];
    int wr_n = 0, rd_n = 0, cs_len = 0;
    logic [18:0] acc_addr = '0;

    always #5 clk = ~clk;

    pkt_mem_seq #(.ACC_CYCLES(ACC)) dut (
        .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
        .in_ready(in_ready), .out_data(out_data), .out_valid(out_valid),
        .out_ready(out_ready), .mem_cs(mem_cs), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .vote_err(vote_err)
    );

    function automatic logic [7:0] f_mem(input logic [18:0] a);
        return (a[7:0] * 8'd3) ^ a[15:8] ^ {5'b0, a[18:16]};
    endfunction

    assign mem_rdata = f_mem(mem_addr);
    assign vote_err  = err_on && mem_rd && (mem_addr == err_addr);

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        ncyc++;
        out_ready = bp ? (ncyc % 3 == 0) : 1'b1;
    end

    always @(posedge clk) begin
        if (out_valid && out_ready && rx_n < 64) begin rx_buf[rx_n] = out_data; rx_n++; end
        if (mem_cs) begin
            if (cs_len == 0) begin
                acc_addr = mem_addr;
                if (mem_wr && wr_n < 64) begin wr_a[wr_n] = mem_addr; wr_d[wr_n] = mem_wdata; wr_n++; end
                if (mem_rd) rd_n++;
            end else if (mem_addr != acc_addr)
                chk(0, "R5 address moved during access", mem_addr, acc_addr);
            cs_len++;
        end else if (cs_len != 0) begin
            chk(cs_len == ACC, "R5 strobe length", cs_len, ACC);
            cs_len = 0;
        end
    end

    always @(posedge clk) if (ncyc == 150000) begin
        miscompares++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", ncyc, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1; in_data = b;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic send_hdr(input logic [7:0] cmd, input logic [18:0] a, input logic [15:0] len);
        send_byte(8'h7E); send_byte(cmd);
        send_byte({5'b10110, a[18:16]}); send_byte(a[15:8]); send_byte(a[7:0]);
        send_byte(len[15:8]); send_byte(len[7:0]);
    endtask

    task automatic clear_logs;
        rx_n = 0; wr_n = 0; rd_n = 0;
    endtask

    task automatic settle(input int len);
        repeat (len * 16 + 40) @(negedge clk);
    endtask

    task automatic do_write(input logic [18:0] a, input int len, input logic [7:0] seed);
        clear_logs();
        send_hdr(8'h57, a, 16'(len));
        for (int i = 0; i < len; i++) send_byte(seed + 8'(i * 7));
        send_byte(8'h0A);
        settle(len);
        chk(wr_n == len, "R6 write count", wr_n, len);
        for (int i = 0; i < len && i < wr_n; i++) begin
            chk(wr_a[i] == a + 19'(i), "R6 write address", wr_a[i], a + 19'(i));
            chk(wr_d[i] == seed + 8'(i * 7), "R2 write data", wr_d[i], seed + 8'(i * 7));
        end
        chk(rx_n == 1, "R7 ack count", rx_n, 1);
        if (rx_n >= 1) chk(rx_buf[0] == 8'h00, "R7 ack byte", rx_buf[0], 0);
    endtask

    task automatic do_read(input logic [18:0] a, input int len);
        clear_logs();
        send_hdr(8'h52, a, 16'(len));
        send_byte(8'h0A);
        settle(len);
        chk(rx_n == len, "R8 read byte count", rx_n, len);
        chk(wr_n == 0, "R8 no writes on read", wr_n, 0);
        for (int i = 0; i < len && i < rx_n; i++)
            chk(rx_buf[i] == f_mem(a + 19'(i)), "R8 read data", rx_buf[i], f_mem(a + 19'(i)));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(in_ready == 1'b1, "R11 in_ready after reset", in_ready, 1);
        chk(out_valid == 1'b0, "R11 out_valid after reset", out_valid, 0);
        chk({mem_cs, mem_rd, mem_wr} == 3'b000, "R11 strobes after reset", {mem_cs, mem_rd, mem_wr}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: junk before start marker is dropped
        clear_logs();
        send_byte(8'h00); send_byte(8'h52); send_byte(8'h0A); send_byte(8'hFF);
        settle(1);
        chk(rx_n == 0 && rd_n == 0 && wr_n == 0, "R1 junk ignored", rx_n + rd_n + wr_n, 0);

        // R6 wrap, R2 upper address bits ignored, R7 ack
        do_write(19'h7FFFE, 4, 8'h31);
        do_write(19'h00010, 0, 8'h00);

        // R8 with back-pressure exercises R10
        bp = 1'b1;
        do_read(19'h12345, 5);
        do_read(19'h7FFFF, 3);
        bp = 1'b0;
        do_read(19'h00100, 0);

        // R3: bad command, next byte re-examined as start
        clear_logs();
        send_byte(8'h7E); send_byte(8'h41);
        send_byte(8'h7E); send_byte(8'h52);
        send_byte(8'h00); send_byte(8'h00); send_byte(8'h20);
        send_byte(8'h00); send_byte(8'h02); send_byte(8'h0A);
        settle(2);
        chk(rx_n == 2, "R3 packet after bad command", rx_n, 2);
        if (rx_n == 2) chk(rx_buf[1] == f_mem(19'h21), "R3 data", rx_buf[1], f_mem(19'h21));

        // R4: bad terminator on read and on write
        clear_logs();
        send_hdr(8'h52, 19'h00300, 16'd3); send_byte(8'h0B);
        settle(3);
        chk(rd_n == 0, "R4 no read on bad terminator", rd_n, 0);
        chk(rx_n == 0, "R4 no output on bad terminator", rx_n, 0);
        clear_logs();
        send_hdr(8'h57, 19'h00400, 16'd2); send_byte(8'h11); send_byte(8'h22); send_byte(8'h0C);
        settle(2);
        chk(wr_n == 2, "R4 writes kept", wr_n, 2);
        chk(rx_n == 0, "R4 no ack on bad terminator", rx_n, 0);

        // R9: voter error mid-burst, with back-pressure
        bp = 1'b1;
        err_on = 1'b1; err_addr = 19'h50103;
        clear_logs();
        send_hdr(8'h52, 19'h50100, 16'd6); send_byte(8'h0A);
        settle(8);
        chk(rx_n == 7, "R9 byte count", rx_n, 7);
        chk(rd_n == 4, "R9 reads stop at error", rd_n, 4);
        if (rx_n == 7) begin
            for (int i = 0; i < 3; i++)
                chk(rx_buf[i] == f_mem(19'h50100 + 19'(i)), "R9 data before error", rx_buf[i], f_mem(19'h50100 + 19'(i)));
            chk(rx_buf[3] == 8'hEE, "R9 error tag", rx_buf[3], 8'hEE);
            chk(rx_buf[4] == 8'h05, "R9 address high", rx_buf[4], 8'h05);
            chk(rx_buf[5] == 8'h01, "R9 address mid", rx_buf[5], 8'h01);
            chk(rx_buf[6] == 8'h03, "R9 address low", rx_buf[6], 8'h03);
        end
        err_on = 1'b0; bp = 1'b0;
        do_read(19'h00055, 1);

        // sweep over lengths and bases
        for (int b = 0; b < 3; b++) begin
            for (int l = 1; l <= 5; l++) begin
                logic [18:0] base;
                base = (b == 0) ? 19'h7FFFD : (b == 1) ? 19'h00040 : 19'h2A5A5;
                bp = (l % 2 == 0);
                do_write(base, l, 8'(l * 17 + b));
                do_read(base, l);
            end
        end
        bp = 1'b0;

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule